// File: doc/BRIEF.md
# Pipelined Command Sequencer With Controller Handoff

This block takes 16-bit command words from a show-ahead command FIFO and runs them strictly in order. Commands it can run itself are NOP, a microsecond wait, a millisecond wait and an ADC sample request. They follow one another with a fixed, repeatable number of clock cycles, so a command list always produces the same timing on the bus. Any opcode with its top bit set cannot be run inside the fabric. For such a command the sequencer stops, presents the opcode and operand to an external microcontroller, and waits for an acknowledge, however long that takes.

Wait durations come from two cascaded prescalers on the system clock. `CLK_PER_US` gives a microsecond tick and `US_PER_MS` gives a millisecond tick. Both prescalers restart with every wait command, so a wait never depends on what happened before it. An ADC sample pulses a start strobe toward an external sampler and holds until that sampler reports done. Opcodes that are not defined are dropped and set a sticky error flag.

Top module: `cmd_sequencer`

## Requirements
- R1: After synchronous reset with an empty FIFO, `idle` is 1 and `fifo_rd`, `adc_start`, `mcu_req` and `err_flag` are all 0.
- R2: While the FIFO is empty, the block never asserts `fifo_rd`, `adc_start` or `mcu_req`, and `idle` stays 1.
- R3: Each command word carries the opcode in bits [15:12] and the operand in bits [11:0]. Commands are popped in FIFO order. Opcode 0 (NOP) takes one cycle, so the next word is popped on the following clock edge.
- R4: Opcode 1 waits for operand microsecond ticks. The next pop comes operand*CLK_PER_US+1 cycles after its own pop. An operand of 0 behaves like a NOP.
- R5: Opcode 2 waits for operand millisecond ticks. The next pop comes operand*CLK_PER_US*US_PER_MS+1 cycles after its own pop. An operand of 0 behaves like a NOP.
- R6: Opcode 3 drives `adc_start` high for exactly one cycle, on the cycle right after its pop, with `adc_chan` equal to operand[CHAN_W-1:0]. The next pop comes on the clock edge after the edge that samples `adc_done` high, so a sampler that raises done L cycles after seeing start gives a pop-to-pop gap of L+3.
- R7: An opcode with bit 3 set (8 to 15) is not popped on arrival. One cycle after it reaches the head, `mcu_req` rises with `mcu_op`/`mcu_arg` showing the command, and both stay stable. The word is popped on the clock edge that samples `mcu_ack` high, and `mcu_req` then falls.
- R8: Opcodes 4 to 7 are popped in one cycle without any start or request activity. They set `err_flag`, which stays 1 until reset.
- R9: `idle` is 0 while any command is in progress (waiting, sampling or handed off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | Command FIFO has no word at its head |
| fifo_data | input | 16 | Head word of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop strobe, consumes the head word at the clock edge |
| adc_start | output | 1 | One-cycle sample request to the ADC sampler |
| adc_chan | output | CHAN_W | Channel select for the sample request |
| adc_done | input | 1 | Sampler finished the requested conversion |
| mcu_req | output | 1 | Handoff request to the external controller |
| mcu_op | output | 4 | Opcode of the handed-off command |
| mcu_arg | output | 12 | Operand of the handed-off command |
| mcu_ack | input | 1 | External controller finished the handed-off command |
| idle | output | 1 | Nothing to execute and no command in progress |
| err_flag | output | 1 | Sticky flag: an undefined opcode was seen |

## Verification
The embedded properties assume a show-ahead FIFO whose head word does not change while it has not been popped. They also assume that `mcu_ack` is raised only while `mcu_req` is high and only for a single cycle. The bench FIFO model meets the first assumption: it changes its head only on a pop, and new words only append at the tail. The bench's controller and sampler models meet the second: they answer only after seeing the matching request or start, with a one-cycle pulse, after a latency that each test sets.

// File: rtl/cmdseq_pkg.sv
`timescale 1ns/1ps
package cmdseq_pkg;

    localparam int OP_W  = 4;
    localparam int ARG_W = 12;
    localparam int CMD_W = OP_W + ARG_W;

    localparam logic [OP_W-1:0] OPC_NOP     = 4'h0;
    localparam logic [OP_W-1:0] OPC_WAIT_US = 4'h1;
    localparam logic [OP_W-1:0] OPC_WAIT_MS = 4'h2;
    localparam logic [OP_W-1:0] OPC_SAMPLE  = 4'h3;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    typedef enum logic [2:0] {
        K_NOP,
        K_WAIT_US,
        K_WAIT_MS,
        K_SAMPLE,
        K_HANDOFF,
        K_BAD
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_WAIT,
        ST_ADC_REQ,
        ST_ADC_WAIT,
        ST_HANDOFF
    } seq_state_e;

    // Top opcode bit marks commands that only the external controller can run.
    function automatic cmd_kind_e classify(input logic [OP_W-1:0] op);
        cmd_kind_e k;
        if (op[OP_W-1]) begin
            k = K_HANDOFF;
        end else begin
            case (op)
                OPC_NOP:     k = K_NOP;
                OPC_WAIT_US: k = K_WAIT_US;
                OPC_WAIT_MS: k = K_WAIT_MS;
                OPC_SAMPLE:  k = K_SAMPLE;
                default:     k = K_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/cmdseq_prescaler.sv
`timescale 1ns/1ps
module cmdseq_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = en && !clr && (cnt == LAST);

    // R4: the counter never leaves its range
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/cmdseq_delay_timer.sv
`timescale 1ns/1ps
module cmdseq_delay_timer #(
    parameter int CLK_PER_US = 200,
    parameter int US_PER_MS  = 1000,
    parameter int CNT_W      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             unit_ms,
    input  logic [CNT_W-1:0] ticks,
    output logic             expire
);
    logic             running;
    logic             ms_mode;
    logic [CNT_W-1:0] remaining;
    logic             us_tick;
    logic             ms_tick;
    logic             unit_tick;

    // Both stages restart on load so every wait is measured from its own start.
    cmdseq_prescaler #(.DIV(CLK_PER_US)) u_us_stage (
        .clk  (clk),
        .rst  (rst),
        .clr  (load),
        .en   (running),
        .tick (us_tick)
    );

    cmdseq_prescaler #(.DIV(US_PER_MS)) u_ms_stage (
        .clk  (clk),
        .rst  (rst),
        .clr  (load),
        .en   (us_tick),
        .tick (ms_tick)
    );

    assign unit_tick = ms_mode ? ms_tick : us_tick;
    assign expire    = running && unit_tick && (remaining == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            ms_mode   <= 1'b0;
            remaining <= '0;
        end else if (load) begin
            running   <= (ticks != '0);
            ms_mode   <= unit_ms;
            remaining <= ticks;
        end else if (running && unit_tick) begin
            remaining <= remaining - 1'b1;
            if (remaining == CNT_W'(1)) begin
                running <= 1'b0;
            end
        end
    end

    // R4/R5: an active wait always has ticks left to count
    p_run_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        running |-> (remaining != '0));

    // R5: expiry ends the wait on the next cycle
    p_expire_stops_r5: assert property (@(posedge clk) disable iff (rst)
        (expire && !load) |=> !running);

endmodule

// File: rtl/cmd_sequencer.sv
`timescale 1ns/1ps
module cmd_sequencer
    import cmdseq_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int US_PER_MS  = 1000,
    parameter int CHAN_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [15:0]       fifo_data,
    output logic              fifo_rd,
    output logic              adc_start,
    output logic [CHAN_W-1:0] adc_chan,
    input  logic              adc_done,
    output logic              mcu_req,
    output logic [3:0]        mcu_op,
    output logic [11:0]       mcu_arg,
    input  logic              mcu_ack,
    output logic              idle,
    output logic              err_flag
);
    seq_state_e st, st_n;
    cmd_t       head;
    cmd_t       cur;
    cmd_kind_e  kind;
    logic       tmr_load;
    logic       tmr_unit_ms;
    logic       tmr_expire;
    logic       bad_seen;

    assign head = cmd_t'(fifo_data);
    assign kind = classify(head.op);

    cmdseq_delay_timer #(
        .CLK_PER_US (CLK_PER_US),
        .US_PER_MS  (US_PER_MS),
        .CNT_W      (ARG_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .unit_ms (tmr_unit_ms),
        .ticks   (head.arg),
        .expire  (tmr_expire)
    );

    always_comb begin
        st_n        = st;
        fifo_rd     = 1'b0;
        tmr_load    = 1'b0;
        tmr_unit_ms = 1'b0;
        bad_seen    = 1'b0;
        case (st)
            ST_FETCH: begin
                if (!fifo_empty) begin
                    case (kind)
                        K_HANDOFF: st_n = ST_HANDOFF;
                        K_SAMPLE: begin
                            fifo_rd = 1'b1;
                            st_n    = ST_ADC_REQ;
                        end
                        K_WAIT_US, K_WAIT_MS: begin
                            fifo_rd     = 1'b1;
                            tmr_unit_ms = (kind == K_WAIT_MS);
                            if (head.arg != '0) begin
                                tmr_load = 1'b1;
                                st_n     = ST_WAIT;
                            end
                        end
                        K_BAD: begin
                            fifo_rd  = 1'b1;
                            bad_seen = 1'b1;
                        end
                        default: fifo_rd = 1'b1;
                    endcase
                end
            end
            ST_WAIT:     if (tmr_expire) st_n = ST_FETCH;
            ST_ADC_REQ:  st_n = ST_ADC_WAIT;
            ST_ADC_WAIT: if (adc_done) st_n = ST_FETCH;
            ST_HANDOFF: begin
                if (mcu_ack) begin
                    fifo_rd = 1'b1;
                    st_n    = ST_FETCH;
                end
            end
            default: st_n = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_FETCH;
            cur      <= '0;
            err_flag <= 1'b0;
        end else begin
            st <= st_n;
            if (st == ST_FETCH && !fifo_empty) begin
                cur <= head;
            end
            if (bad_seen) begin
                err_flag <= 1'b1;
            end
        end
    end

    assign adc_start = (st == ST_ADC_REQ);
    assign adc_chan  = cur.arg[CHAN_W-1:0];
    assign mcu_req   = (st == ST_HANDOFF);
    assign mcu_op    = cur.op;
    assign mcu_arg   = cur.arg;
    assign idle      = (st == ST_FETCH) && fifo_empty;

    // R2: a pop never hits an empty FIFO
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    // R2: an idle cycle starts no sample and no handoff in the next one
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        idle |=> (!adc_start && !mcu_req));

    // R6: the sample strobe lasts a single cycle
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    // R7: the request holds with stable contents until acknowledged
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mcu_req && !mcu_ack) |=> (mcu_req && $stable(mcu_op) && $stable(mcu_arg)));

    // R7: no pop while the handoff is pending
    p_no_pop_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (mcu_req && !mcu_ack) |-> !fifo_rd);

    // R7: acknowledge ends the request
    p_req_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (mcu_req && mcu_ack) |=> !mcu_req);

    // R8: the error flag never clears outside reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R9: a sample or handoff in progress is never reported idle
    p_busy_not_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (adc_start || mcu_req) |-> !idle);

endmodule

// File: tb/tb_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_cmd_sequencer;
    localparam int CPU = 4;
    localparam int UPM = 5;
    localparam int CHW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic           fifo_empty = 1'b1;
    logic [15:0]    fifo_data  = '0;
    logic           fifo_rd;
    logic           adc_start;
    logic [CHW-1:0] adc_chan;
    logic           adc_done;
    logic           mcu_req;
    logic [3:0]     mcu_op;
    logic [11:0]    mcu_arg;
    logic           mcu_ack;
    logic           idle;
    logic           err_flag;

    cmd_sequencer #(.CLK_PER_US(CPU), .US_PER_MS(UPM), .CHAN_W(CHW)) dut (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .adc_start(adc_start), .adc_chan(adc_chan),
        .adc_done(adc_done), .mcu_req(mcu_req), .mcu_op(mcu_op),
        .mcu_arg(mcu_arg), .mcu_ack(mcu_ack), .idle(idle), .err_flag(err_flag)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;
    int adc_lat = 3;
    int mcu_lat = 5;

    logic [15:0] fq[$];
    logic [15:0] exp_q[$];
    int          pop_t[$];
    int          adc_t[$];
    int          adc_c[$];
    int          req_t[$];
    int          req_w[$];
    logic        req_d = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: feeds the FIFO model and the scoreboard queue together.
    task automatic push(input logic [3:0] op, input logic [11:0] arg);
        fq.push_back({op, arg});
        exp_q.push_back({op, arg});
        fifo_empty = 1'b0;
        fifo_data  = fq[0];
    endtask

    task automatic clear_logs();
        pop_t.delete(); adc_t.delete(); adc_c.delete();
        req_t.delete(); req_w.delete();
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(idle && fq.size() == 0) && n < 5000);
        repeat (2) @(negedge clk);
    endtask

    // FIFO model and monitor: pops, compares with scoreboard, stamps events.
    always @(posedge clk) begin
        logic [15:0] got;
        logic [15:0] want;
        cyc <= cyc + 1;
        if (fifo_rd) begin
            if (fq.size() == 0) begin
                chk("R2 pop from empty FIFO", 1, 0);
            end else begin
                got = fq.pop_front();
                fifo_empty <= (fq.size() == 0);
                fifo_data  <= (fq.size() > 0) ? fq[0] : 16'h0;
                if (exp_q.size() == 0) begin
                    chk("R3 pop with nothing expected", 1, 0);
                end else begin
                    want = exp_q.pop_front();
                    chk("R3 pop order", int'(got), int'(want));
                end
                pop_t.push_back(cyc);
            end
        end
        if (adc_start) begin
            adc_t.push_back(cyc);
            adc_c.push_back(int'(adc_chan));
        end
        if (mcu_req && !req_d) begin
            req_t.push_back(cyc);
            req_w.push_back(int'({mcu_op, mcu_arg}));
        end
        req_d <= mcu_req;
    end

    // Sampler model: done pulse adc_lat cycles after the start strobe.
    int acnt = 0;
    always @(posedge clk) begin
        if (rst) begin
            acnt     <= 0;
            adc_done <= 1'b0;
        end else begin
            adc_done <= (acnt == 1);
            if (adc_start) acnt <= adc_lat;
            else if (acnt != 0) acnt <= acnt - 1;
        end
    end

    // Controller model: single-cycle acknowledge after mcu_lat cycles of request.
    int mcnt = 0;
    always @(posedge clk) begin
        if (rst) begin
            mcu_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mcu_ack) begin
            mcu_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mcu_req) begin
            if (mcnt == mcu_lat - 1) mcu_ack <= 1'b1;
            mcnt <= mcnt + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int idle_miss;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 idle", int'(idle), 1);
        chk("R1 fifo_rd", int'(fifo_rd), 0);
        chk("R1 mcu_req", int'(mcu_req), 0);
        chk("R1 adc_start", int'(adc_start), 0);
        chk("R1 err_flag", int'(err_flag), 0);

        // R2: empty FIFO stays quiet
        clear_logs();
        idle_miss = 0;
        repeat (20) begin
            @(negedge clk);
            if (!idle) idle_miss++;
        end
        chk("R2 idle held", idle_miss, 0);
        chk("R2 pops", pop_t.size(), 0);
        chk("R2 adc starts", adc_t.size(), 0);
        chk("R2 requests", req_t.size(), 0);

        // R3: back-to-back NOPs
        clear_logs();
        push(4'h0, 12'h001); push(4'h0, 12'h002); push(4'h0, 12'h003); push(4'h0, 12'h004);
        wait_idle();
        chk("R3 pop count", pop_t.size(), 4);
        chk("R3 gap 1", pop_t[1] - pop_t[0], 1);
        chk("R3 gap 2", pop_t[3] - pop_t[2], 1);

        // R4: microsecond waits, with zero operand; R9 busy while waiting
        clear_logs();
        push(4'h1, 12'd3); push(4'h1, 12'd0); push(4'h1, 12'd1); push(4'h0, 12'h000);
        repeat (3) @(negedge clk);
        chk("R9 idle low during wait", int'(idle), 0);
        wait_idle();
        chk("R4 pop count", pop_t.size(), 4);
        chk("R4 us wait 3", pop_t[1] - pop_t[0], 3 * CPU + 1);
        chk("R4 us wait 0", pop_t[2] - pop_t[1], 1);
        chk("R4 us wait 1", pop_t[3] - pop_t[2], CPU + 1);
        chk("R9 idle after wait", int'(idle), 1);

        // R5: millisecond waits
        clear_logs();
        push(4'h2, 12'd2); push(4'h2, 12'd1); push(4'h2, 12'd0); push(4'h0, 12'h000);
        wait_idle();
        chk("R5 pop count", pop_t.size(), 4);
        chk("R5 ms wait 2", pop_t[1] - pop_t[0], 2 * CPU * UPM + 1);
        chk("R5 ms wait 1", pop_t[2] - pop_t[1], CPU * UPM + 1);
        chk("R5 ms wait 0", pop_t[3] - pop_t[2], 1);

        // R6: sample with latency 3
        clear_logs();
        adc_lat = 3;
        push(4'h3, 12'h0A5); push(4'h0, 12'h000);
        wait_idle();
        chk("R6 start count", adc_t.size(), 1);
        chk("R6 start follows pop", adc_t[0] - pop_t[0], 1);
        chk("R6 channel", adc_c[0], 5);
        chk("R6 gap latency 3", pop_t[1] - pop_t[0], 3 + 3);

        // R6: sample with latency 1
        clear_logs();
        adc_lat = 1;
        push(4'h3, 12'h00C); push(4'h0, 12'h000);
        wait_idle();
        chk("R6 channel 12", adc_c[0], 12);
        chk("R6 gap latency 1", pop_t[1] - pop_t[0], 1 + 3);

        // R7: handoff with a slow controller
        clear_logs();
        mcu_lat = 5;
        push(4'h0, 12'h000); push(4'h9, 12'h123); push(4'h0, 12'h000);
        repeat (4) @(negedge clk);
        chk("R9 idle low during handoff", int'(idle), 0);
        wait_idle();
        chk("R7 request count", req_t.size(), 1);
        chk("R7 request word", req_w[0], 16'h9123);
        chk("R7 request delay", req_t[0] - pop_t[0], 2);
        chk("R7 pop waits for ack", pop_t[1] - pop_t[0], 5 + 2);
        chk("R7 next after handoff", pop_t[2] - pop_t[1], 1);

        // R7: handoff with a fast controller
        clear_logs();
        mcu_lat = 1;
        push(4'h0, 12'h000); push(4'hF, 12'hABC); push(4'h0, 12'h000);
        wait_idle();
        chk("R7 request word fast", req_w[0], 16'hFABC);
        chk("R7 fast gap", pop_t[1] - pop_t[0], 1 + 2);
        chk("R7 request dropped", int'(mcu_req), 0);

        // R8: undefined opcodes
        clear_logs();
        chk("R8 flag clear before", int'(err_flag), 0);
        push(4'h5, 12'h007); push(4'h0, 12'h000); push(4'h7, 12'hFFF); push(4'h0, 12'h000);
        wait_idle();
        chk("R8 pop count", pop_t.size(), 4);
        chk("R8 skip one cycle", pop_t[1] - pop_t[0], 1);
        chk("R8 no start", adc_t.size(), 0);
        chk("R8 no request", req_t.size(), 0);
        chk("R8 flag set", int'(err_flag), 1);
        push(4'h1, 12'd1);
        wait_idle();
        chk("R8 flag sticky", int'(err_flag), 1);

        // R1: reset clears the flag
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 flag after reset", int'(err_flag), 0);
        chk("R1 idle after reset", int'(idle), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule